// File: doc/BRIEF.md
# Serial Card Interface Master

This block is a processor-programmed serial master for memory cards used in SPI mode. Software sets the transfer format through a small register bus. The block then drives the serial clock, one active-low chip select and the data-out line, and it samples data-in. Each transfer unit is 8 or 16 bits long.

Transmit and receive each have one holding register in front of the shift engine, with no FIFO. A second word can be queued while the first is shifting, so units can run back to back without a gap. The bit order, the inversion of transmitted and received bits, an internal loopback, the level on data-out when no data is being sent, and a receive-only mode are all set in the configuration register. The serial rate comes from a 4-bit divide code. Four status sources each have an interrupt enable.

Register map (3-bit address, 16-bit data): 0 = configuration (read/write), 1 = interrupt enable (read/write, bits 3:0), 2 = transmit holding (write), 3 = receive holding (read), 4 = status (read). Configuration bits: 0 run enable, 1 wide (16-bit unit), 2 LSB-first, 3 transmit invert, 4 receive invert, 5 loopback, 6 idle level, 7 lockstep, 8 receive-only, 15:12 rate code. Status and interrupt bits: 0 receive ready, 1 transmit holding free, 2 transmit finished (sticky), 3 receive finished (sticky), 4 busy (status only), 5 overrun (status only, sticky).

Top module: `spi_card_master`

## Requirements
- R1: After reset, chip select is high, serial clock and data-out are low, the interrupt is low, and status reads 0x0002.
- R2: The serial clock idles low and chip select stays low for a whole unit. Data-out changes only while the clock is low, and data-in is sampled on the rising edge. The first rising edge comes one half period after chip select falls.
- R3: Configuration bit 1 selects a 16-bit unit; when it is clear the unit is 8 bits. An 8-bit unit sends bits 7:0 of the transmit word and returns zeros in receive bits 15:8. A unit has exactly that many rising edges.
- R4: Configuration bit 2 set shifts bit 0 first in both directions. Clear, the most significant bit of the unit goes first.
- R5: Configuration bit 3 inverts every transmitted bit, and bit 4 inverts every received bit, each on its own.
- R6: With configuration bit 5 set, received bits come from the block's own data-out, and the external data-in is ignored.
- R7: Data-out holds the level of configuration bit 6 when no unit runs. With configuration bit 8 set and no transmit word queued, units run anyway and drive that level throughout.
- R8: A rate code k from 1 to 15 in configuration bits 15:12 gives a serial clock half period of k system clocks. Code 0 starts no unit.
- R9: A word written while a unit shifts is sent right after it. Chip select stays low and the clock period stays uniform across the boundary.
- R10: A transmit write while the holding register is full is discarded and sets status bit 5. A status read clears that bit.
- R11: With configuration bit 7 set, no unit starts while the receive holding register is full. With it clear, the newest unit overwrites the receive holding register.
- R12: The interrupt is the OR of the status bits 3:0 that are enabled in the interrupt enable register. A status read clears bits 2 and 3, and reading the receive register clears bit 0.
- R13: With configuration bit 0 clear, no unit starts and a running serial clock freezes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Interrupt request, registered |
| ser_clk | output | 1 | Serial clock |
| ser_cs_n | output | 1 | Chip select, active low |
| ser_dout | output | 1 | Serial data to the card |
| ser_din | input | 1 | Serial data from the card |

## Verification
The assertions assume that software changes the format fields of the configuration register only while no unit is running. Rate, width, bit order or inversion changes in the middle of a unit are outside their scope. They also assume that data-in from the card is stable around each rising serial clock edge. The bench writes the configuration only after chip select has returned high. Its card model changes data-in only on falling serial clock edges or on the falling edge of chip select.

// File: rtl/spi_card_pkg.sv
package spi_card_pkg;

  localparam int REG_W  = 16;
  localparam int RATE_W = 4;

  localparam logic [2:0] ADR_CFG  = 3'd0;
  localparam logic [2:0] ADR_IEN  = 3'd1;
  localparam logic [2:0] ADR_TX   = 3'd2;
  localparam logic [2:0] ADR_RX   = 3'd3;
  localparam logic [2:0] ADR_STAT = 3'd4;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic [2:0]        spare;
    logic              rx_only;
    logic              lockstep;
    logic              idle_lvl;
    logic              loop;
    logic              rx_inv;
    logic              tx_inv;
    logic              lsb_first;
    logic              wide;
    logic              run_en;
  } cfg_t;

endpackage

// File: rtl/spi_rate_div.sv
module spi_rate_div #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [RW-1:0] rate,
  output logic          tick
);

  logic [RW-1:0] cnt_q;

  assign tick = run && (rate != '0) && (cnt_q == rate - RW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + RW'(1);
  end

  // R8
  property p_zero_rate_silent;
    @(posedge clk) disable iff (rst) (rate == '0) |-> !tick;
  endproperty
  zero_rate_silent_chk: assert property (p_zero_rate_silent);

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int MAXW = 16,
  localparam int IW = $clog2(MAXW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            avail,
  input  logic            use_tx,
  input  logic [MAXW-1:0] tx_word,
  input  logic            wide,
  input  logic            lsb_first,
  input  logic            tx_inv,
  input  logic            rx_inv,
  input  logic            loop,
  input  logic            idle_lvl,
  input  logic            ser_din,
  output logic            take,
  output logic            ending,
  output logic            busy,
  output logic            ser_clk,
  output logic            ser_dout,
  output logic [MAXW-1:0] rx_word
);

  logic            busy_q, sclk_q, dout_q, txmode_q;
  logic [IW-1:0]   idx_q;
  logic [MAXW-1:0] tx_q, rx_q;
  logic [IW-1:0]   last_idx, rx_pos, nxt_pos, first_pos;
  logic            rise, fall, din_eff;

  assign last_idx  = wide ? IW'(MAXW - 1) : IW'(MAXW / 2 - 1);
  assign rise      = busy_q && tick && !sclk_q;
  assign fall      = busy_q && tick && sclk_q;
  assign ending    = fall && (idx_q == last_idx);
  assign take      = avail && (!busy_q || ending);
  assign din_eff   = loop ? dout_q : ser_din;

  assign rx_pos    = lsb_first ? idx_q : last_idx - idx_q;
  assign nxt_pos   = lsb_first ? idx_q + IW'(1) : last_idx - idx_q - IW'(1);
  assign first_pos = lsb_first ? '0 : last_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      sclk_q   <= 1'b0;
      dout_q   <= 1'b0;
      txmode_q <= 1'b0;
      idx_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else if (take) begin
      busy_q   <= 1'b1;
      sclk_q   <= 1'b0;
      idx_q    <= '0;
      tx_q     <= tx_word;
      txmode_q <= use_tx;
      rx_q     <= '0;
      dout_q   <= use_tx ? (tx_word[first_pos] ^ tx_inv) : idle_lvl;
    end else if (ending) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      dout_q <= idle_lvl;
    end else if (rise) begin
      sclk_q         <= 1'b1;
      rx_q[rx_pos]   <= din_eff ^ rx_inv;
    end else if (fall) begin
      sclk_q <= 1'b0;
      idx_q  <= idx_q + IW'(1);
      dout_q <= txmode_q ? (tx_q[nxt_pos] ^ tx_inv) : idle_lvl;
    end else if (!busy_q) begin
      dout_q <= idle_lvl;
    end
  end

  assign busy     = busy_q;
  assign ser_clk  = sclk_q;
  assign ser_dout = dout_q;
  assign rx_word  = rx_q;

  // R2
  property p_clk_low_when_idle;
    @(posedge clk) disable iff (rst) !busy_q |-> !sclk_q;
  endproperty
  clk_low_when_idle_chk: assert property (p_clk_low_when_idle);

  // R2
  property p_dout_steady_high;
    @(posedge clk) disable iff (rst) (sclk_q && $past(sclk_q)) |-> $stable(dout_q);
  endproperty
  dout_steady_high_chk: assert property (p_dout_steady_high);

  // R3
  property p_index_in_unit;
    @(posedge clk) disable iff (rst) busy_q |-> (idx_q <= last_idx);
  endproperty
  index_in_unit_chk: assert property (p_index_in_unit);

endmodule

// File: rtl/spi_card_master.sv
module spi_card_master
  import spi_card_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  output logic             irq,
  output logic             ser_clk,
  output logic             ser_cs_n,
  output logic             ser_dout,
  input  logic             ser_din
);

  localparam int UNIT_MAX = REG_W;
  localparam int NSRC     = 4;

  cfg_t              cfg_q;
  logic [NSRC-1:0]   ien_q;
  logic [REG_W-1:0]  tx_hold_q, rx_hold_q, rdata_q;
  logic              tx_full_q, rx_full_q, txfin_q, rxfin_q, ovr_q, irq_q;
  logic              tick, take, ending, busy, avail;
  logic [UNIT_MAX-1:0] rx_word;
  logic              wr_cfg, wr_ien, wr_tx, rd_rx, rd_stat;
  logic [NSRC-1:0]   src;
  logic [REG_W-1:0]  stat_word;

  assign wr_cfg  = bus_we && (bus_addr == ADDR_W'(ADR_CFG));
  assign wr_ien  = bus_we && (bus_addr == ADDR_W'(ADR_IEN));
  assign wr_tx   = bus_we && (bus_addr == ADDR_W'(ADR_TX));
  assign rd_rx   = bus_re && (bus_addr == ADDR_W'(ADR_RX));
  assign rd_stat = bus_re && (bus_addr == ADDR_W'(ADR_STAT));

  assign avail = cfg_q.run_en && (cfg_q.rate != '0) &&
                 (tx_full_q || cfg_q.rx_only) &&
                 (!cfg_q.lockstep || (!rx_full_q && !ending));

  assign src       = {rxfin_q, txfin_q, ~tx_full_q, rx_full_q};
  assign stat_word = {{(REG_W-6){1'b0}}, ovr_q, busy, src};

  spi_rate_div #(.RW(RATE_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .run  (busy && cfg_q.run_en),
    .rate (cfg_q.rate),
    .tick (tick)
  );

  spi_shift_engine #(.MAXW(UNIT_MAX)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .avail     (avail),
    .use_tx    (tx_full_q),
    .tx_word   (tx_hold_q),
    .wide      (cfg_q.wide),
    .lsb_first (cfg_q.lsb_first),
    .tx_inv    (cfg_q.tx_inv),
    .rx_inv    (cfg_q.rx_inv),
    .loop      (cfg_q.loop),
    .idle_lvl  (cfg_q.idle_lvl),
    .ser_din   (ser_din),
    .take      (take),
    .ending    (ending),
    .busy      (busy),
    .ser_clk   (ser_clk),
    .ser_dout  (ser_dout),
    .rx_word   (rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      ien_q     <= '0;
      tx_hold_q <= '0;
      tx_full_q <= 1'b0;
      rx_hold_q <= '0;
      rx_full_q <= 1'b0;
      txfin_q   <= 1'b0;
      rxfin_q   <= 1'b0;
      ovr_q     <= 1'b0;
      rdata_q   <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= cfg_t'(bus_wdata);
      if (wr_ien) ien_q <= bus_wdata[NSRC-1:0];

      if (take && tx_full_q) begin
        tx_full_q <= 1'b0;
      end else if (wr_tx && !tx_full_q) begin
        tx_hold_q <= bus_wdata;
        tx_full_q <= 1'b1;
      end

      if (wr_tx && tx_full_q) ovr_q <= 1'b1;
      else if (rd_stat)       ovr_q <= 1'b0;

      if (ending) begin
        rx_hold_q <= rx_word;
        rx_full_q <= 1'b1;
      end else if (rd_rx) begin
        rx_full_q <= 1'b0;
      end

      if (ending && !take) txfin_q <= 1'b1;
      else if (rd_stat)    txfin_q <= 1'b0;

      if (ending)       rxfin_q <= 1'b1;
      else if (rd_stat) rxfin_q <= 1'b0;

      if (bus_re) begin
        case (bus_addr)
          ADDR_W'(ADR_CFG):  rdata_q <= cfg_q;
          ADDR_W'(ADR_IEN):  rdata_q <= {{(REG_W-NSRC){1'b0}}, ien_q};
          ADDR_W'(ADR_RX):   rdata_q <= rx_hold_q;
          ADDR_W'(ADR_STAT): rdata_q <= stat_word;
          default:           rdata_q <= '0;
        endcase
      end

      irq_q <= |(src & ien_q);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;
  assign ser_cs_n  = ~busy;

  // R10
  property p_overrun_flag;
    @(posedge clk) disable iff (rst) (wr_tx && tx_full_q) |=> ovr_q;
  endproperty
  overrun_flag_chk: assert property (p_overrun_flag);

  // R8
  property p_zero_rate_idle;
    @(posedge clk) disable iff (rst) (cfg_q.rate == '0 && !busy) |=> !busy;
  endproperty
  zero_rate_idle_chk: assert property (p_zero_rate_idle);

  // R11
  property p_lockstep_wait;
    @(posedge clk) disable iff (rst) (cfg_q.lockstep && rx_full_q && !busy) |=> !busy;
  endproperty
  lockstep_wait_chk: assert property (p_lockstep_wait);

  // R13
  property p_disabled_idle;
    @(posedge clk) disable iff (rst) (!cfg_q.run_en && !busy) |=> !busy;
  endproperty
  disabled_idle_chk: assert property (p_disabled_idle);

  // R13
  property p_disabled_freeze;
    @(posedge clk) disable iff (rst) (!cfg_q.run_en && busy) |=> $stable(ser_clk);
  endproperty
  disabled_freeze_chk: assert property (p_disabled_freeze);

endmodule

// File: tb/tb_spi_card_master.sv
`timescale 1ns/100ps
module tb_spi_card_master;

  localparam logic [2:0] A_CFG = 3'd0, A_IEN = 3'd1, A_TX = 3'd2, A_RX = 3'd3, A_ST = 3'd4;

  logic clk = 1'b0, rst = 1'b1, we = 1'b0, re = 1'b0, din = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic irq, sclk, csn, dout;

  spi_card_master dut (
    .clk(clk), .rst(rst), .bus_we(we), .bus_re(re), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq), .ser_clk(sclk),
    .ser_cs_n(csn), .ser_dout(dout), .ser_din(din)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  int rise_cnt = 0, cs_rise = 0;
  logic cap [0:63];
  realtime rise_t [0:63];
  realtime cs_fall_t = 0.0;
  logic [63:0] slave = '0;

  always @(posedge sclk) begin
    if (rise_cnt < 64) begin
      cap[rise_cnt]    = dout;
      rise_t[rise_cnt] = $realtime;
    end
    rise_cnt++;
  end
  always @(negedge sclk) din = slave[rise_cnt % 64];
  always @(negedge csn) begin
    cs_fall_t = $realtime;
    din = slave[rise_cnt % 64];
  end
  always @(posedge csn) cs_rise++;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (csn == 1'b0) @(negedge clk);
  endtask

  task automatic mon_clear();
    rise_cnt = 0; cs_rise = 0;
  endtask

  function automatic logic [15:0] mkcfg(input bit en, input bit wide, input bit lsb, input bit ti,
                                        input bit ri, input bit lp, input bit idle, input bit lock,
                                        input bit rxo, input int rate);
    return {rate[3:0], 3'b000, rxo, lock, idle, lp, ri, ti, lsb, wide, en};
  endfunction

  function automatic logic txbit(input logic [15:0] w, input int j, input int n, input bit lsb, input bit ti);
    return (lsb ? w[j] : w[n-1-j]) ^ ti;
  endfunction

  function automatic logic [15:0] exp_rx(input int off, input int n, input bit lsb, input bit ri);
    logic [15:0] r = '0;
    for (int j = 0; j < n; j++) r[lsb ? j : n-1-j] = slave[(off + j) % 64] ^ ri;
    return r;
  endfunction

  function automatic bit gaps_ok(input int from, input int to, input int rate);
    bit ok = 1;
    for (int i = from + 1; i < to; i++) begin
      realtime d = rise_t[i] - rise_t[i-1] - 10.0 * rate;
      if (d > 0.1 || d < -0.1) ok = 0;
    end
    return ok;
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v, w1, w2, w3;
    logic [63:0] act, exp;
    bit ok;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    mon_clear();

    // R1 reset state
    chk(csn == 1 && sclk == 0 && dout == 0 && irq == 0, "R1 pins", {csn, sclk, dout, irq}, 4'b1000);
    rd(A_ST, v);
    chk(v == 16'h0002, "R1 status", v, 16'h0002);

    // Sweep: width, order, tx/rx inversion, two rates
    for (int c = 0; c < 16; c++) begin
      for (int r = 1; r <= 2; r++) begin
        bit wide = c[0], lsb = c[1], ti = c[2], ri = c[3];
        int n = wide ? 16 : 8;
        slave = {64'hA5C3_1E7F_0096_D2B4} ^ {16{c[3:0]}} ^ (64'(r) << 5);
        w1 = 16'hB38D ^ (16'(c) * 16'h1111) ^ 16'(r);
        mon_clear();
        wr(A_CFG, mkcfg(1, wide, lsb, ti, ri, 0, 0, 0, 0, r));
        wr(A_TX, w1);
        wait_idle();
        chk(rise_cnt == n, "R3 edge count", 64'(rise_cnt), 64'(n));
        act = '0; exp = '0;
        for (int j = 0; j < n; j++) begin
          act[j] = cap[j];
          exp[j] = txbit(w1, j, n, lsb, ti);
        end
        chk(act == exp, "R4/R5 tx bits", act, exp);
        chk(gaps_ok(0, n, r), "R8 half period", 64'(r), 64'(r));
        ok = (rise_t[0] - cs_fall_t - 5.0 * r) < 0.1 && (rise_t[0] - cs_fall_t - 5.0 * r) > -0.1;
        chk(ok && cs_rise == 1, "R2 first edge and select", 64'(cs_rise), 64'd1);
        rd(A_RX, v);
        chk(v == exp_rx(0, n, lsb, ri), "R4/R5 R3 rx word", v, exp_rx(0, n, lsb, ri));
      end
    end

    // R9 back to back, R11 overwrite without lockstep
    slave = 64'h1234_5678_9ABC_DEF0;
    w1 = 16'hC0DE; w2 = 16'h5A0F;
    mon_clear();
    wr(A_CFG, mkcfg(1, 1, 0, 0, 0, 0, 0, 0, 0, 2));
    wr(A_TX, w1);
    repeat (2) @(negedge clk);
    wr(A_TX, w2);
    wait_idle();
    chk(rise_cnt == 32 && cs_rise == 1, "R9 one selection", {32'(rise_cnt), 32'(cs_rise)}, {32'd32, 32'd1});
    chk(gaps_ok(0, 32, 2), "R9 uniform clock", 64'd0, 64'd0);
    act = '0; exp = '0;
    for (int j = 0; j < 32; j++) begin
      act[j] = cap[j];
      exp[j] = (j < 16) ? txbit(w1, j, 16, 0, 0) : txbit(w2, j - 16, 16, 0, 0);
    end
    chk(act == exp, "R9 stream", act, exp);
    rd(A_ST, v);
    chk(v == 16'h000F, "R12 status after units", v, 16'h000F);
    rd(A_RX, v);
    chk(v == exp_rx(16, 16, 0, 0), "R11 overwrite", v, exp_rx(16, 16, 0, 0));

    // R10 overrun
    w3 = 16'hFFFF;
    mon_clear();
    wr(A_CFG, mkcfg(1, 1, 0, 0, 0, 0, 0, 0, 0, 4));
    wr(A_TX, w1);
    repeat (2) @(negedge clk);
    wr(A_TX, w2);
    wr(A_TX, w3);
    rd(A_ST, v);
    chk(v[5] == 1'b1, "R10 overrun set", v, 16'h0020);
    rd(A_ST, v);
    chk(v[5] == 1'b0, "R10 overrun cleared", v, 16'h0000);
    wait_idle();
    act = '0; exp = '0;
    for (int j = 0; j < 32; j++) begin
      act[j] = cap[j];
      exp[j] = (j < 16) ? txbit(w1, j, 16, 0, 0) : txbit(w2, j - 16, 16, 0, 0);
    end
    chk(rise_cnt == 32 && act == exp, "R10 write dropped", act, exp);
    rd(A_RX, v);

    // R11 lockstep
    mon_clear();
    wr(A_CFG, mkcfg(1, 0, 0, 0, 0, 0, 0, 1, 0, 1));
    wr(A_TX, 16'h0081);
    repeat (2) @(negedge clk);
    wr(A_TX, 16'h007E);
    wait_idle();
    repeat (10) @(negedge clk);
    chk(rise_cnt == 8 && csn == 1, "R11 waits for read", 64'(rise_cnt), 64'd8);
    rd(A_ST, v);
    chk(v[1:0] == 2'b01, "R11 holding states", v[1:0], 2'b01);
    rd(A_RX, v);
    chk(v == exp_rx(0, 8, 0, 0), "R11 first word", v, exp_rx(0, 8, 0, 0));
    wait_idle();
    chk(rise_cnt == 16, "R11 resumes", 64'(rise_cnt), 64'd16);
    rd(A_RX, v);
    chk(v == exp_rx(8, 8, 0, 0), "R11 second word", v, exp_rx(8, 8, 0, 0));

    // R6 loopback
    slave = '0;
    mon_clear();
    wr(A_CFG, mkcfg(1, 1, 0, 1, 0, 1, 0, 0, 0, 1));
    wr(A_TX, 16'h3C5A);
    wait_idle();
    rd(A_RX, v);
    chk(v == ~16'h3C5A, "R6 loopback", v, ~16'h3C5A);

    // R7 receive-only with idle high
    slave = 64'h0F0F_3355_AA99_6C6C;
    mon_clear();
    wr(A_CFG, mkcfg(1, 0, 0, 0, 0, 0, 1, 1, 1, 1));
    wait_idle();
    act = '0;
    for (int j = 0; j < 8; j++) act[j] = cap[j];
    chk(rise_cnt == 8 && act[7:0] == 8'hFF && dout == 1, "R7 idle level", act, 64'hFF);
    rd(A_RX, v);
    chk(v == exp_rx(0, 8, 0, 0), "R7 rx-only word", v, exp_rx(0, 8, 0, 0));
    wait_idle();
    chk(rise_cnt == 16, "R7 continues", 64'(rise_cnt), 64'd16);
    wr(A_CFG, mkcfg(1, 0, 0, 0, 0, 0, 1, 0, 0, 1));
    rd(A_RX, v);

    // R8 rate code zero
    mon_clear();
    wr(A_CFG, mkcfg(1, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    wr(A_TX, 16'h00A5);
    repeat (40) @(negedge clk);
    chk(csn == 1 && rise_cnt == 0, "R8 code zero", 64'(rise_cnt), 64'd0);
    wr(A_CFG, mkcfg(1, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    wait_idle();
    chk(rise_cnt == 8, "R8 starts after code", 64'(rise_cnt), 64'd8);
    rd(A_RX, v);

    // R13 run enable
    mon_clear();
    wr(A_CFG, mkcfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    wr(A_TX, 16'h005A);
    repeat (40) @(negedge clk);
    chk(csn == 1 && rise_cnt == 0, "R13 disabled", 64'(rise_cnt), 64'd0);
    wr(A_CFG, mkcfg(1, 0, 0, 0, 0, 0, 0, 0, 0, 1));
    wait_idle();
    chk(rise_cnt == 8, "R13 enabled", 64'(rise_cnt), 64'd8);
    rd(A_RX, v);
    rd(A_ST, v);

    // R12 interrupts
    wr(A_IEN, 16'h0001);
    repeat (3) @(negedge clk);
    chk(irq == 0, "R12 quiet", irq, 1'b0);
    wr(A_TX, 16'h0033);
    wait_idle();
    repeat (2) @(negedge clk);
    chk(irq == 1, "R12 rx ready", irq, 1'b1);
    rd(A_RX, v);
    repeat (2) @(negedge clk);
    chk(irq == 0, "R12 rx read clears", irq, 1'b0);
    wr(A_IEN, 16'h0004);
    repeat (2) @(negedge clk);
    chk(irq == 1, "R12 tx finished", irq, 1'b1);
    rd(A_ST, v);
    repeat (2) @(negedge clk);
    chk(irq == 0, "R12 status read clears", irq, 1'b0);

    finished = 1;
    summary();
    $finish;
  end

endmodule